// File: doc/BRIEF.md
# ATA PIO Register Access Sequencer

This block is the host end of a parallel ATA task-file port in programmed I/O mode. A small command port asks for one register read or one register write at a time. The block then drives the chip-select pair, the three device address lines, the read and write strobes (both active low) and a 16-bit data bus. The data bus is split into an input, an output and an output enable, so that the pad ring can build the tri-state buffer.

Every access moves exactly one 16-bit word and runs through three timed phases:
- address setup, with both strobes high;
- strobe active, with one strobe low;
- recovery, with both strobes high again.

The length of each phase comes from a per-mode table. The table is held in nanoseconds and converted to clock cycles when the design is elaborated, using the clock frequency parameter. Software selects a PIO mode, and the block loads the cycle counts for that mode.

A separate request produces a long active-low reset pulse for the device.

Software must wait while busy is high before it issues the next access. A byte-wide register access uses the low 8 bits of the word.

Top module: `ata_pio_seq`

## Requirements
- R1: The 4-bit register code selects the chip-select with bit 3: value 0 drives `ata_cs_n_o[0]` low and value 1 drives `ata_cs_n_o[1]` low. Bits 2:0 appear on `ata_addr_o`. Both stay constant for the whole access. When idle, `ata_cs_n_o` is 2'b11 and `ata_addr_o` is 0.
- R2: An access moves one full 16-bit word. A write presents `req_wdata_i` on the bus, and a read returns all 16 bits taken from the bus.
- R3: A request is accepted only while `busy_o` is low. `busy_o` rises in the cycle after acceptance and stays high until the recovery phase ends. A request made while busy is dropped and causes no later access.
- R4: An access is S cycles of setup with both strobes high, then A cycles with only the selected strobe low, then R cycles with both strobes high while the chip-select is still asserted. `busy_o` falls after those cycles. A read pulses only the read strobe, and a write pulses only the write strobe.
- R5: The cycle counts (setup, active, recovery) at 80 MHz are: mode 0 = 5/13/8, mode 1 = 4/10/8, mode 2 = 2/8/8, mode 3 = 2/6/5. Each count is the table time in ns × clock MHz / 1000, truncated.
- R6: A mode value above 3 on `mode_i` selects the mode 3 timing.
- R7: After reset the timing is that of mode 0 until `mode_set_i` loads another mode.
- R8: A count that truncates to zero is used as one cycle. With a 10 MHz clock, every phase therefore lasts exactly one cycle.
- R9: A read captures the bus on the clock edge at which the read strobe returns high. `rd_valid_o` is a one-cycle pulse in the following cycle, and `rd_data_o` holds the captured word. A bus change after that edge does not affect the result.
- R10: `ata_data_oe_o` is high throughout all three phases of a write and low otherwise, including during reads.
- R11: A pulse on `dev_rst_req_i` holds `ata_reset_n_o` low for exactly RST_CYCLES cycles, starting in the cycle after the request. A request made while the pulse is running neither extends it nor restarts it.
- R12: After `rst_ni` the block is idle: busy low, both strobes high, both chip-selects high, output enable low, `rd_valid_o` low and the device reset released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_reg_i | input | 4 | Register code {chip-select, address[2:0]} |
| req_wdata_i | input | 16 | Write word |
| busy_o | output | 1 | Access in progress |
| rd_valid_o | output | 1 | Read word valid pulse |
| rd_data_o | output | 16 | Read word |
| mode_set_i | input | 1 | Load new PIO mode |
| mode_i | input | 3 | Requested PIO mode |
| dev_rst_req_i | input | 1 | Start device reset pulse |
| ata_reset_n_o | output | 1 | Device reset, active low |
| ata_cs_n_o | output | 2 | Chip-selects, active low |
| ata_addr_o | output | 3 | Device register address |
| ata_dior_n_o | output | 1 | Read strobe, active low |
| ata_diow_n_o | output | 1 | Write strobe, active low |
| ata_data_i | input | 16 | Bus input from pad |
| ata_data_o | output | 16 | Bus output to pad |
| ata_data_oe_o | output | 1 | Bus output enable |

## Verification
The assertions watch these properties on every cycle:
- the two strobes are never low together;
- no strobe is low while idle;
- at most one chip-select is low;
- the address and chip-select do not move within an access;
- the output enable is never high while the read strobe is low;
- an acceptance always raises busy;
- each read strobe is followed by exactly one valid pulse.

Only the bench scenarios can show the exact phase lengths for each mode, including clamping, the default after reset and the zero-to-one rule. The same holds for the word actually captured versus a later bus value, dropped requests, and the exact length of the reset pulse.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_RECOV} phase_e;

  localparam int NUM_MODES = 4;

  // per-mode times in ns
  function automatic int t_setup_ns(int m);
    case (m)
      0: return 70;
      1: return 50;
      2: return 30;
      default: return 30;
    endcase
  endfunction

  function automatic int t_active_ns(int m);
    case (m)
      0: return 165;
      1: return 125;
      2: return 100;
      default: return 80;
    endcase
  endfunction

  function automatic int t_recov_ns(int m);
    case (m)
      0: return 100;
      1: return 100;
      2: return 100;
      default: return 70;
    endcase
  endfunction

  function automatic int ns_to_cyc(int ns, int mhz);
    int c;
    c = (ns * mhz) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/ata_pio_timing.sv
module ata_pio_timing
  import ata_pio_pkg::*;
#(
  parameter int CLK_MHZ = 80,
  parameter int MODE_W  = 3,
  parameter int CNT_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_set_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [CNT_W-1:0]  setup_o,
  output logic [CNT_W-1:0]  active_o,
  output logic [CNT_W-1:0]  recov_o
);

  localparam int IDX_W = $clog2(NUM_MODES);
  localparam logic [MODE_W-1:0] TOP_MODE = MODE_W'(NUM_MODES - 1);

  logic [CNT_W-1:0] lut_s [NUM_MODES];
  logic [CNT_W-1:0] lut_a [NUM_MODES];
  logic [CNT_W-1:0] lut_r [NUM_MODES];

  genvar m;
  generate
    for (m = 0; m < NUM_MODES; m++) begin : g_lut
      assign lut_s[m] = CNT_W'(ns_to_cyc(t_setup_ns(m), CLK_MHZ));
      assign lut_a[m] = CNT_W'(ns_to_cyc(t_active_ns(m), CLK_MHZ));
      assign lut_r[m] = CNT_W'(ns_to_cyc(t_recov_ns(m), CLK_MHZ));
    end
  endgenerate

  logic [IDX_W-1:0] idx;
  always_comb begin
    if (mode_i > TOP_MODE) idx = IDX_W'(NUM_MODES - 1);
    else                   idx = mode_i[IDX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_o  <= lut_s[0];
      active_o <= lut_a[0];
      recov_o  <= lut_r[0];
    end else if (mode_set_i) begin
      setup_o  <= lut_s[idx];
      active_o <= lut_a[idx];
      recov_o  <= lut_r[idx];
    end
  end

endmodule

// File: rtl/ata_pio_devrst.sv
module ata_pio_devrst #(
  parameter int RST_CYCLES = 8_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic dev_rst_n_o
);

  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (!act_q) begin
      if (req_i) begin
        cnt_q <= CW'(RST_CYCLES - 1);
        act_q <= 1'b1;
      end
    end else if (cnt_q == '0) begin
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign dev_rst_n_o = ~act_q;

  AST_RST_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dev_rst_n_o) |-> $past(req_i)); // R11

endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W:0]   req_reg_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [CNT_W-1:0]  setup_i,
  input  logic [CNT_W-1:0]  active_i,
  input  logic [CNT_W-1:0]  recov_i,
  output logic              busy_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [1:0]        cs_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dior_n_o,
  output logic              diow_n_o,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);

  localparam int NUM_CS = 2;

  phase_e            ph_q;
  logic [CNT_W-1:0]  cnt_q, act_q, rec_q;
  logic [ADDR_W:0]   reg_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rd_pend_q, rd_valid_q;
  logic              accept;

  assign accept = req_valid_i && (ph_q == PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_IDLE;
      cnt_q      <= '0;
      act_q      <= '0;
      rec_q      <= '0;
      reg_q      <= '0;
      wr_q       <= 1'b0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      rd_pend_q  <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_pend_q  <= 1'b0;
      rd_valid_q <= rd_pend_q;
      unique case (ph_q)
        PH_IDLE: if (accept) begin
          reg_q   <= req_reg_i;
          wr_q    <= req_write_i;
          wdata_q <= req_wdata_i;
          cnt_q   <= setup_i - 1'b1;
          act_q   <= active_i;
          rec_q   <= recov_i;
          ph_q    <= PH_SETUP;
        end
        PH_SETUP: if (cnt_q == '0) begin
          ph_q  <= PH_STROBE;
          cnt_q <= act_q - 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        PH_STROBE: if (cnt_q == '0) begin
          ph_q  <= PH_RECOV;
          cnt_q <= rec_q - 1'b1;
          if (!wr_q) begin
            rdata_q   <= data_i;   // sampled as the read strobe rises
            rd_pend_q <= 1'b1;
          end
        end else cnt_q <= cnt_q - 1'b1;
        PH_RECOV: if (cnt_q == '0) ph_q <= PH_IDLE;
                  else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o     = (ph_q != PH_IDLE);
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rdata_q;
  assign addr_o     = busy_o ? reg_q[ADDR_W-1:0] : '0;
  assign dior_n_o   = ~((ph_q == PH_STROBE) && !wr_q);
  assign diow_n_o   = ~((ph_q == PH_STROBE) && wr_q);
  assign data_oe_o  = busy_o && wr_q;
  assign data_o     = data_oe_o ? wdata_q : '0;

  genvar c;
  generate
    for (c = 0; c < NUM_CS; c++) begin : g_cs
      assign cs_n_o[c] = ~(busy_o && (reg_q[ADDR_W] == c[0]));
    end
  endgenerate

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> busy_o); // R3
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(addr_o) && $stable(cs_n_o))); // R1
  AST_ONE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o)); // R1
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dior_n_o && !diow_n_o)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (dior_n_o && diow_n_o && !data_oe_o)); // R4
  AST_OE_NOT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> dior_n_o); // R10
  AST_RDV_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o); // R9
  AST_RDV_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dior_n_o) |=> rd_valid_o); // R9
  AST_COUNT_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |-> (setup_i != '0 && active_i != '0 && recov_i != '0)); // R8

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq #(
  parameter int CLK_MHZ    = 80,
  parameter int RST_CYCLES = 8_000_000,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 3,
  parameter int MODE_W     = 3,
  parameter int CNT_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W:0]   req_reg_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              mode_set_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              dev_rst_req_i,
  output logic              ata_reset_n_o,
  output logic [1:0]        ata_cs_n_o,
  output logic [ADDR_W-1:0] ata_addr_o,
  output logic              ata_dior_n_o,
  output logic              ata_diow_n_o,
  input  logic [DATA_W-1:0] ata_data_i,
  output logic [DATA_W-1:0] ata_data_o,
  output logic              ata_data_oe_o
);

  logic [CNT_W-1:0] t_setup, t_active, t_recov;

  ata_pio_timing #(.CLK_MHZ(CLK_MHZ), .MODE_W(MODE_W), .CNT_W(CNT_W)) u_timing (
    .clk_i, .rst_ni, .mode_set_i, .mode_i,
    .setup_o(t_setup), .active_o(t_active), .recov_o(t_recov)
  );

  ata_pio_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_engine (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_reg_i, .req_wdata_i,
    .setup_i(t_setup), .active_i(t_active), .recov_i(t_recov),
    .busy_o, .rd_valid_o, .rd_data_o,
    .cs_n_o(ata_cs_n_o), .addr_o(ata_addr_o),
    .dior_n_o(ata_dior_n_o), .diow_n_o(ata_diow_n_o),
    .data_i(ata_data_i), .data_o(ata_data_o), .data_oe_o(ata_data_oe_o)
  );

  ata_pio_devrst #(.RST_CYCLES(RST_CYCLES)) u_devrst (
    .clk_i, .rst_ni, .req_i(dev_rst_req_i), .dev_rst_n_o(ata_reset_n_o)
  );

endmodule

// File: tb/tb_ata_pio_seq.sv
`timescale 1ns/1ps
module tb_ata_pio_seq;

  localparam int RST_LEN = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_write = 0, mode_set = 0, dev_rst_req = 0;
  logic [3:0]  req_reg = 0;
  logic [15:0] req_wdata = 0, bus_in = 0;
  logic [2:0]  mode = 0;
  logic        busy, rd_valid, ata_rst_n, dior_n, diow_n, oe;
  logic [15:0] rd_data, bus_out;
  logic [1:0]  cs_n;
  logic [2:0]  addr;

  ata_pio_seq #(.CLK_MHZ(80), .RST_CYCLES(RST_LEN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_reg_i(req_reg), .req_wdata_i(req_wdata), .busy_o(busy), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .mode_set_i(mode_set), .mode_i(mode), .dev_rst_req_i(dev_rst_req),
    .ata_reset_n_o(ata_rst_n), .ata_cs_n_o(cs_n), .ata_addr_o(addr),
    .ata_dior_n_o(dior_n), .ata_diow_n_o(diow_n), .ata_data_i(bus_in),
    .ata_data_o(bus_out), .ata_data_oe_o(oe)
  );

  // slow-clock instance for the zero-count rule
  logic        req2 = 0;
  logic        busy2, rdv2, rstn2, dior2, diow2, oe2;
  logic [15:0] rdd2, bo2;
  logic [1:0]  cs2;
  logic [2:0]  a2;
  ata_pio_seq #(.CLK_MHZ(10), .RST_CYCLES(RST_LEN)) dut2 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req2), .req_write_i(1'b1),
    .req_reg_i(4'h7), .req_wdata_i(16'h1234), .busy_o(busy2), .rd_valid_o(rdv2),
    .rd_data_o(rdd2), .mode_set_i(1'b0), .mode_i(3'd0), .dev_rst_req_i(1'b0),
    .ata_reset_n_o(rstn2), .ata_cs_n_o(cs2), .ata_addr_o(a2),
    .ata_dior_n_o(dior2), .ata_diow_n_o(diow2), .ata_data_i(16'h0),
    .ata_data_o(bo2), .ata_data_oe_o(oe2)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cyc(int ns);
    int c = ns * 80 / 1000;
    return c < 1 ? 1 : c;
  endfunction
  function automatic int eff(int m);
    return m > 3 ? 3 : m;
  endfunction
  function automatic int exp_s(int m);
    int t[4] = '{70, 50, 30, 30};
    return cyc(t[eff(m)]);
  endfunction
  function automatic int exp_a(int m);
    int t[4] = '{165, 125, 100, 80};
    return cyc(t[eff(m)]);
  endfunction
  function automatic int exp_r(int m);
    int t[4] = '{100, 100, 100, 70};
    return cyc(t[eff(m)]);
  endfunction

  task automatic set_mode(input int m);
    @(negedge clk); mode_set = 1; mode = 3'(m);
    @(negedge clk); mode_set = 0;
  endtask

  // runs one access and checks phases, pins and data
  task automatic access(input logic [3:0] rg, input bit wr, input logic [15:0] wd,
                        input logic [15:0] rdv, input int m, input string tag);
    int s = 0, a = 0, r = 0, idx = 0, last_a = -1, rv_idx = -1, guard = 0;
    bit pin_ok = 1, oe_ok = 1, strobe_ok = 1;
    logic [15:0] got = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_reg = rg; req_wdata = wd; bus_in = rdv;
    @(negedge clk);
    req_valid = 0; req_wdata = ~wd;
    chk(busy === 1'b1, "R3 busy after accept", busy, 1);
    while (busy === 1'b1 && guard < 200) begin
      guard++;
      if (cs_n !== (rg[3] ? 2'b01 : 2'b10) || addr !== rg[2:0]) pin_ok = 0;
      if (oe !== wr || (wr && bus_out !== wd)) oe_ok = 0;
      if ((wr && dior_n !== 1'b1) || (!wr && diow_n !== 1'b1)) strobe_ok = 0;
      if ((wr ? diow_n : dior_n) === 1'b0) begin a++; last_a = idx; end
      else if (a == 0) s++;
      else begin r++; if (r == 1) bus_in = ~rdv; end
      if (rd_valid === 1'b1) begin rv_idx = idx; got = rd_data; end
      idx++;
      @(negedge clk);
    end
    if (rd_valid === 1'b1) begin rv_idx = idx; got = rd_data; end
    chk(pin_ok, {tag, " R1 cs/addr held"}, rg, rg);
    chk(oe_ok, {tag, " R10/R2 bus drive"}, oe, wr);
    chk(strobe_ok, {tag, " R4 wrong strobe"}, 0, 0);
    chk(s == exp_s(m) && a == exp_a(m) && r == exp_r(m), {tag, " R4/R5 phase lengths"},
        s * 10000 + a * 100 + r, exp_s(m) * 10000 + exp_a(m) * 100 + exp_r(m));
    chk(cs_n === 2'b11 && addr === 3'd0 && oe === 1'b0, {tag, " R1 idle pins"}, cs_n, 3);
    if (!wr) begin
      chk(rv_idx == last_a + 2, {tag, " R9 valid timing"}, rv_idx, last_a + 2);
      chk(got === rdv, {tag, " R9/R2 read word"}, got, rdv);
    end else begin
      chk(rv_idx == -1, {tag, " R9 no valid on write"}, rv_idx, -1);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int low, m;
    bit quiet;
    void'($urandom(32'd7391));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12
    chk(busy === 0 && dior_n === 1 && diow_n === 1 && cs_n === 2'b11 && oe === 0 &&
        rd_valid === 0 && ata_rst_n === 1, "R12 reset state", busy, 0);

    // R7: default mode 0
    access(4'h7, 1, 16'hA5C3, 16'h0, 0, "R7 default write");
    access(4'hE, 0, 16'h0, 16'hBEEF, 0, "R7 default read");

    // R5: each mode, both chip-selects
    for (int k = 0; k < 4; k++) begin
      set_mode(k);
      access(4'(k + 1), 1, 16'(16'h1111 * k), 16'h0, k, "R5 write");
      access(4'(8 + k), 0, 16'h0, 16'(16'h0F0F ^ (k * 16'h1357)), k, "R5 read");
    end

    // R6: clamp
    for (int k = 4; k < 8; k++) begin
      set_mode(k);
      access(4'h6, 0, 16'h0, 16'hFFFF, k, "R6 clamp");
    end

    // R3: request while busy is dropped
    set_mode(2);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_reg = 4'h2; req_wdata = 16'h5555;
    @(negedge clk);
    req_reg = 4'hF; req_write = 0;
    quiet = 1;
    repeat (3) begin
      @(negedge clk);
      if (addr !== 3'd2 || cs_n !== 2'b10) quiet = 0;
    end
    req_valid = 0;
    while (busy === 1'b1) begin
      if (dior_n !== 1'b1) quiet = 0;
      @(negedge clk);
    end
    repeat (5) begin
      @(negedge clk);
      if (busy !== 0 || cs_n !== 2'b11 || dior_n !== 1) quiet = 0;
    end
    chk(quiet, "R3 request while busy dropped", quiet, 1);

    // R8: 10 MHz instance, every phase one cycle
    @(negedge clk); req2 = 1;
    @(negedge clk); req2 = 0;
    chk(busy2 === 1 && diow2 === 1 && cs2 === 2'b10 && a2 === 3'd7, "R8 setup 1", diow2, 1);
    @(negedge clk);
    chk(diow2 === 0 && bo2 === 16'h1234, "R8 strobe 1", diow2, 0);
    @(negedge clk);
    chk(busy2 === 1 && diow2 === 1, "R8 recovery 1", busy2, 1);
    @(negedge clk);
    chk(busy2 === 0, "R8 done", busy2, 0);

    // R11: device reset pulse length and retrigger
    @(negedge clk); dev_rst_req = 1;
    @(negedge clk); dev_rst_req = 0;
    low = 0;
    for (int i = 0; i < 60; i++) begin
      if (ata_rst_n === 1'b0) low++;
      if (i == 5) dev_rst_req = 1;
      if (i == 6) dev_rst_req = 0;
      @(negedge clk);
    end
    chk(low == RST_LEN, "R11 reset pulse length", low, RST_LEN);
    chk(ata_rst_n === 1'b1, "R11 reset released", ata_rst_n, 1);

    // random mix
    for (int n = 0; n < 30; n++) begin
      m = $urandom_range(0, 7);
      set_mode(m);
      access(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 16'($urandom),
             16'($urandom), m, "R2 random");
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule